// File: doc/BRIEF.md
# Paired Command and Data FIFO with Watermarks and Error Flags

This block gives a serial bus controller its two queues. The transmit queue takes 11-bit command words from software and hands them to the bus engine. The receive queue takes 8-bit bytes from the engine and hands them to software. Each queue holds 64 entries. It reports full and empty, and it raises a level request once its fill level crosses a watermark that software programs. For the receive side the watermark marks the queue as almost full. For the transmit side it marks the queue as almost empty.

An illegal access does not disturb the queue. A pop from an empty queue and a push into a full queue both set a sticky flag. Any set flag raises one combined error request. Software flushes a queue with a level-sensitive clear bit: it writes the bit to 1 and later back to 0. While the bit is 1 the queue is held empty, its error flags are held at zero and pushes are discarded. Pops are also without effect: read data keeps its value and no flag is set.

A 14-bit control word carries the two clear bits and the two watermarks, and it reads back as written. A 12-bit status word carries the error flags and the level flags at fixed positions. All state is registered. A push or pop is seen in the status word one clock after the edge that takes it. Popped data appears on the read-data port after that same edge.

Top module: `fifo_pair`

## Requirements
- R1: Each queue holds exactly 64 entries: after 64 accepted pushes the full flag is set, and the 65th push is not stored.
- R2: Entries leave each queue in the order they entered. The popped word appears on the read-data port one clock after the pop.
- R3: A push while the queue is full is dropped and sets that queue's write-error flag (status bit 1 for receive, bit 7 for transmit).
- R4: A pop while the queue is empty leaves the read data unchanged and sets that queue's read-error flag (status bit 0 for receive, bit 6 for transmit).
- R5: Error flags are sticky. They clear only through that queue's clear bit or through reset. `fifo_err_req` is high exactly when any of the four flags is set.
- R6: The control word has the receive clear at bit 0, the transmit clear at bit 1, the receive watermark at [7:2] and the transmit watermark at [13:8], and it reads back as written. While a clear bit is 1, that queue is empty, has no error flags, and ignores pushes.
- R7: `rx_af_req` is high when receive occupancy is greater than or equal to the receive watermark.
- R8: `tx_ae_req` is high when transmit occupancy is less than or equal to the transmit watermark.
- R9: The status word has receive full at bit 2, receive empty at bit 3, transmit empty at bit 10 and transmit full at bit 11, with all other bits zero. After reset the status reads 0x408 and the control word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 14 | Control word write value |
| ctrl_rdata | output | 14 | Control word readback |
| status | output | 12 | Status word |
| tx_push | input | 1 | Software pushes a command word |
| tx_wdata | input | 11 | Command word to push |
| tx_pop | input | 1 | Engine pops a command word |
| tx_rdata | output | 11 | Last popped command word |
| rx_push | input | 1 | Engine pushes a received byte |
| rx_wdata | input | 8 | Byte to push |
| rx_pop | input | 1 | Software pops a byte |
| rx_rdata | output | 8 | Last popped byte |
| rx_af_req | output | 1 | Receive almost-full request |
| tx_ae_req | output | 1 | Transmit almost-empty request |
| fifo_err_req | output | 1 | Any error flag set |

## Verification
The properties for write-error and read-error on a full or empty queue assume that no control write lands in the same cycle. Such a write could start a clear, and a clear overrides the flag. The stimulus never issues a control write together with a push or pop. Stickiness is checked only in cycles where no clear is active or being written. Every strobe is driven on the falling edge and held for exactly one clock. The stimulus never pushes and pops the same queue in one cycle, so the bench's queue model needs no ordering rule for that case.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
    localparam int FIFO_DEPTH = 64;
    localparam int TX_W       = 11;
    localparam int RX_W       = 8;
    localparam int THR_W      = 6;
    localparam int CTRL_W     = 2 + 2 * THR_W;
    localparam int STAT_W     = 12;

    localparam int S_RX_RERR  = 0;
    localparam int S_RX_WERR  = 1;
    localparam int S_RX_FULL  = 2;
    localparam int S_RX_EMPTY = 3;
    localparam int S_TX_RERR  = 6;
    localparam int S_TX_WERR  = 7;
    localparam int S_TX_EMPTY = 10;
    localparam int S_TX_FULL  = 11;

    typedef struct packed {
        logic rerr;
        logic werr;
        logic full;
        logic empty;
    } q_flags_t;
endpackage

// File: rtl/fifo_pair_queue.sv
module fifo_pair_queue #(
    parameter int W         = 8,
    parameter int DEPTH     = 64,
    parameter int THR_W     = 6,
    parameter bit HIGH_MARK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    input  logic [THR_W-1:0] thr,
    output logic [W-1:0]     rdata,
    output fifo_pair_pkg::q_flags_t flags,
    output logic             wm_req
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          rerr_q, werr_q;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            rerr_q <= 1'b0;
            werr_q <= 1'b0;
            rdata  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            rerr_q <= 1'b0;
            werr_q <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
                rdata  <= mem[rd_ptr];
            end
            count <= count + CW'(do_push) - CW'(do_pop);
            if (push && full) werr_q <= 1'b1;
            if (pop && empty) rerr_q <= 1'b1;
        end
    end

    generate
        if (HIGH_MARK) begin : g_high
            assign wm_req = (count >= CW'(thr));
        end else begin : g_low
            assign wm_req = (count <= CW'(thr));
        end
    endgenerate

    assign flags = '{rerr: rerr_q, werr: werr_q, full: full, empty: empty};
endmodule

// File: rtl/fifo_pair_csr.sv
module fifo_pair_csr
    import fifo_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output logic              rx_clr,
    output logic              tx_clr,
    output logic [THR_W-1:0]  rx_thr,
    output logic [THR_W-1:0]  tx_thr,
    input  q_flags_t          rx_flags,
    input  q_flags_t          tx_flags,
    output logic [STAT_W-1:0] status,
    output logic              err_req
);
    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ctrl_q <= '0;
        else if (we) ctrl_q <= wdata;
    end

    assign rdata  = ctrl_q;
    assign rx_clr = ctrl_q[0];
    assign tx_clr = ctrl_q[1];
    assign rx_thr = ctrl_q[2 +: THR_W];
    assign tx_thr = ctrl_q[2 + THR_W +: THR_W];

    always_comb begin
        status             = '0;
        status[S_RX_RERR]  = rx_flags.rerr;
        status[S_RX_WERR]  = rx_flags.werr;
        status[S_RX_FULL]  = rx_flags.full;
        status[S_RX_EMPTY] = rx_flags.empty;
        status[S_TX_RERR]  = tx_flags.rerr;
        status[S_TX_WERR]  = tx_flags.werr;
        status[S_TX_EMPTY] = tx_flags.empty;
        status[S_TX_FULL]  = tx_flags.full;
    end

    assign err_req = rx_flags.rerr | rx_flags.werr | tx_flags.rerr | tx_flags.werr;
endmodule

// File: rtl/fifo_pair.sv
module fifo_pair
    import fifo_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic [STAT_W-1:0] status,
    input  logic              tx_push,
    input  logic [TX_W-1:0]   tx_wdata,
    input  logic              tx_pop,
    output logic [TX_W-1:0]   tx_rdata,
    input  logic              rx_push,
    input  logic [RX_W-1:0]   rx_wdata,
    input  logic              rx_pop,
    output logic [RX_W-1:0]   rx_rdata,
    output logic              rx_af_req,
    output logic              tx_ae_req,
    output logic              fifo_err_req
);
    logic             rx_clr, tx_clr;
    logic [THR_W-1:0] rx_thr, tx_thr;
    q_flags_t         rx_flags, tx_flags;

    fifo_pair_csr u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctrl_we),
        .wdata    (ctrl_wdata),
        .rdata    (ctrl_rdata),
        .rx_clr   (rx_clr),
        .tx_clr   (tx_clr),
        .rx_thr   (rx_thr),
        .tx_thr   (tx_thr),
        .rx_flags (rx_flags),
        .tx_flags (tx_flags),
        .status   (status),
        .err_req  (fifo_err_req)
    );

    fifo_pair_queue #(
        .W(TX_W), .DEPTH(FIFO_DEPTH), .THR_W(THR_W), .HIGH_MARK(1'b0)
    ) u_txq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tx_clr),
        .push   (tx_push),
        .wdata  (tx_wdata),
        .pop    (tx_pop),
        .thr    (tx_thr),
        .rdata  (tx_rdata),
        .flags  (tx_flags),
        .wm_req (tx_ae_req)
    );

    fifo_pair_queue #(
        .W(RX_W), .DEPTH(FIFO_DEPTH), .THR_W(THR_W), .HIGH_MARK(1'b1)
    ) u_rxq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rx_clr),
        .push   (rx_push),
        .wdata  (rx_wdata),
        .pop    (rx_pop),
        .thr    (rx_thr),
        .rdata  (rx_rdata),
        .flags  (rx_flags),
        .wm_req (rx_af_req)
    );
endmodule

// File: rtl/fifo_pair_chk.sv
module fifo_pair_chk
    import fifo_pair_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_we,
    input logic [CTRL_W-1:0] ctrl_wdata,
    input logic [CTRL_W-1:0] ctrl_rdata,
    input logic [STAT_W-1:0] status,
    input logic              tx_push,
    input logic              rx_pop,
    input logic              tx_ae_req,
    input logic              fifo_err_req
);
    assert_full_xor_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[S_TX_FULL] && status[S_TX_EMPTY]) && !(status[S_RX_FULL] && status[S_RX_EMPTY]));

    assert_tx_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        status[S_TX_FULL] && tx_push && !ctrl_rdata[1] && !ctrl_we |=> status[S_TX_WERR]);

    assert_rx_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status[S_RX_EMPTY] && rx_pop && !ctrl_rdata[0] && !ctrl_we |=> status[S_RX_RERR]);

    assert_tx_werr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status[S_TX_WERR] && !ctrl_rdata[1] && !(ctrl_we && ctrl_wdata[1]) |=> status[S_TX_WERR]);

    assert_err_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_err_req == (status[S_RX_RERR] | status[S_RX_WERR] | status[S_TX_RERR] | status[S_TX_WERR]));

    assert_rx_clear_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[0] |=> status[S_RX_EMPTY] && !status[S_RX_RERR] && !status[S_RX_WERR]);

    assert_empty_ae_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status[S_TX_EMPTY] |-> tx_ae_req);
endmodule

bind fifo_pair fifo_pair_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (ctrl_we),
    .ctrl_wdata   (ctrl_wdata),
    .ctrl_rdata   (ctrl_rdata),
    .status       (status),
    .tx_push      (tx_push),
    .rx_pop       (rx_pop),
    .tx_ae_req    (tx_ae_req),
    .fifo_err_req (fifo_err_req)
);

// File: tb/fifo_pair_tb.sv
`timescale 1ns/1ps
module fifo_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [13:0] ctrl_wdata = '0;
    logic [13:0] ctrl_rdata;
    logic [11:0] status;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [10:0] tx_wdata = '0, tx_rdata;
    logic [7:0]  rx_wdata = '0, rx_rdata;
    logic        rx_af_req, tx_ae_req, fifo_err_req;

    int nchk = 0;
    int nerr = 0;
    bit tx_clr_m = 0, rx_clr_m = 0;
    logic [10:0] txq[$];
    logic [7:0]  rxq[$];
    logic [10:0] exp_tx, last_tx = '0;
    logic [7:0]  exp_rx, last_rx = '0;
    bit tx_chk = 0, rx_chk = 0;

    always #10 clk = ~clk;

    fifo_pair u_dut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items as the design is told to pop
    always @(posedge clk) begin
        if (tx_pop && !tx_clr_m && txq.size() > 0) begin exp_tx = txq.pop_front(); tx_chk = 1; end
        if (rx_pop && !rx_clr_m && rxq.size() > 0) begin exp_rx = rxq.pop_front(); rx_chk = 1; end
    end
    always @(negedge clk) begin
        if (tx_chk) begin check("R2 tx order", 32'(tx_rdata), 32'(exp_tx)); last_tx = exp_tx; tx_chk = 0; end
        if (rx_chk) begin check("R2 rx order", 32'(rx_rdata), 32'(exp_rx)); last_rx = exp_rx; rx_chk = 0; end
    end

    task automatic wr_ctrl(logic [13:0] v);
        ctrl_we = 1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 0;
        @(negedge clk);
        tx_clr_m = v[1]; rx_clr_m = v[0];
        if (v[1]) txq.delete();
        if (v[0]) rxq.delete();
    endtask

    task automatic push_tx(logic [10:0] d);
        tx_push = 1; tx_wdata = d;
        if (!tx_clr_m && txq.size() < 64) txq.push_back(d);
        @(negedge clk); tx_push = 0;
    endtask
    task automatic push_rx(logic [7:0] d);
        rx_push = 1; rx_wdata = d;
        if (!rx_clr_m && rxq.size() < 64) rxq.push_back(d);
        @(negedge clk); rx_push = 0;
    endtask
    task automatic pop_tx();
        tx_pop = 1; @(negedge clk); tx_pop = 0;
    endtask
    task automatic pop_rx();
        rx_pop = 1; @(negedge clk); rx_pop = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        check("R9 reset status", 32'(status), 32'h408);
        check("R9 reset ctrl", 32'(ctrl_rdata), 32'h0);
        check("R5 reset err req", 32'(fifo_err_req), 32'h0);

        // R6 control layout: rx thr 4 at [7:2], tx thr 2 at [13:8]
        wr_ctrl(14'h0210);
        check("R6 ctrl readback", 32'(ctrl_rdata), 32'h210);

        // R8 tx almost-empty around threshold 2
        push_tx(11'h101); check("R8 ae cnt1", 32'(tx_ae_req), 32'h1);
        push_tx(11'h702); check("R8 ae cnt2", 32'(tx_ae_req), 32'h1);
        push_tx(11'h0a3); check("R8 ae cnt3", 32'(tx_ae_req), 32'h0);
        check("R9 tx not empty", 32'(status[10]), 32'h0);
        repeat (3) pop_tx();
        check("R9 tx empty again", 32'(status[10]), 32'h1);

        // R1 / R3 fill transmit queue
        for (int i = 0; i < 64; i++) push_tx(11'(i * 37 + 5));
        check("R1 tx full", 32'(status[11]), 32'h1);
        check("R3 no werr yet", 32'(status[7]), 32'h0);
        push_tx(11'h7ff);
        check("R3 tx werr", 32'(status[7]), 32'h1);
        check("R5 err req", 32'(fifo_err_req), 32'h1);
        for (int i = 0; i < 64; i++) pop_tx();
        @(negedge clk);
        check("R1 tx empty after 64", 32'(status[10]), 32'h1);

        // R4 pop empty transmit queue
        pop_tx();
        check("R4 tx rdata held", 32'(tx_rdata), 32'(last_tx));
        check("R4 tx rerr", 32'(status[6]), 32'h1);
        repeat (5) @(negedge clk);
        push_tx(11'h055);
        check("R5 tx werr sticky", 32'(status[7]), 32'h1);
        check("R5 tx rerr sticky", 32'(status[6]), 32'h1);

        // R6 clear transmit queue
        wr_ctrl(14'h0212);
        check("R6 tx cleared empty", 32'(status[10]), 32'h1);
        check("R6 tx errs cleared", 32'(status[7:6]), 32'h0);
        push_tx(11'h123);
        check("R6 push ignored in clear", 32'(status[10]), 32'h1);
        wr_ctrl(14'h0210);
        check("R5 err req low", 32'(fifo_err_req), 32'h0);
        push_tx(11'h321); pop_tx(); @(negedge clk);

        // R7 receive almost-full at threshold 4
        push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
        check("R7 af cnt3", 32'(rx_af_req), 32'h0);
        push_rx(8'h44);
        check("R7 af cnt4", 32'(rx_af_req), 32'h1);
        repeat (4) pop_rx();
        @(negedge clk);
        check("R7 af cnt0", 32'(rx_af_req), 32'h0);
        pop_rx();
        check("R4 rx rdata held", 32'(rx_rdata), 32'(last_rx));
        check("R4 rx rerr", 32'(status[0]), 32'h1);
        for (int i = 0; i < 64; i++) push_rx(8'(i * 13 + 1));
        check("R1 rx full", 32'(status[2]), 32'h1);
        push_rx(8'hee);
        check("R3 rx werr", 32'(status[1]), 32'h1);
        for (int i = 0; i < 64; i++) pop_rx();
        @(negedge clk);
        check("R1 rx empty", 32'(status[3]), 32'h1);
        wr_ctrl(14'h0211);
        check("R6 rx errs cleared", 32'(status[1:0]), 32'h0);
        wr_ctrl(14'h0210);
        check("R9 final status", 32'(status), 32'h408);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule